// File: doc/BRIEF.md
# Time-Slot Interchange Switch

A non-blocking switch for PCM voice and data channels. Eight serial input lines each carry 32 eight-bit channels per frame, one bit per clock. That gives 256 bit positions per frame and 256 switchable channels. Every frame the block deserialises all input channels into a frame-wide data store. For each output slot it fetches the byte chosen by a per-slot routing entry and serialises it onto one of eight output lines.

Each routing entry has two parts. The low word names the source channel as a stream and a channel number. The high word carries three flags: slot drive, message mode and a status bit. When message mode is set, the slot transmits the low word itself as a host-supplied byte instead of switched traffic. A separate control line reports the status flag of all 256 entries, one per bit time, every frame. A global drive-enable input can silence all outputs at once. The per-slot drive flags apply only while it is high.

The host writes one routing entry per clock through a simple write port. Tri-state pads are outside the block. Each output line comes with its own enable, and its data is forced low whenever that enable is low.

Top module: `tsi_switch`

## Requirements
- R1: While reset is active, and afterwards until the host enables a slot, every `tx_oe` bit, every `tx_ser` bit and `ctrl_ser` are low. All routing entries are cleared by reset.
- R2: Output stream o, channel c, carries the byte received in the previous frame on the input location named by routing entry {o[2:0], c[4:0]}. The entry's low word holds the source stream in bits [7:5] and the source channel in bits [4:0]. Any source may feed any number of outputs.
- R3: When bit 2 (drive) of a routing entry's high word is 0, that output slot has `tx_oe` low and `tx_ser` low for all eight of its bit times.
- R4: When bit 0 (message) of a routing entry's high word is 1, the slot transmits the entry's 8-bit low word instead of switched data.
- R5: `ctrl_ser` in the cycle after frame position p equals bit 1 of the high word of routing entry p. The entry index and the frame position share the same 8-bit value.
- R6: While `drive_en` is low, all `tx_oe` and `tx_ser` bits are low in that same cycle. Internal state keeps running, so traffic resumes aligned once `drive_en` returns high.
- R7: Data is double-buffered by frame. A byte received in frame N is sent only in frame N+1, including the case of input channel 31 feeding output channel 0.
- R8: A cycle with `frame_sync` high is frame position 0. The position then counts up by one each clock and wraps from 255 to 0.
- R9: Channels are MSB first. Input bit 7-b of channel c is sampled at position 8c+b. Output bit 7-b of slot c is presented in the cycle after position 8c+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Marks frame position 0 |
| rx_ser | input | 8 | Serial input streams |
| drive_en | input | 1 | Global output drive enable |
| map_we | input | 1 | Routing entry write strobe |
| map_addr | input | 8 | Routing entry index {output stream, channel} |
| map_lo | input | 8 | Routing low word: source location or message byte |
| map_hi | input | 3 | Routing flags: [2] drive, [1] status, [0] message |
| tx_ser | output | 8 | Serial output streams |
| tx_oe | output | 8 | Per-stream output enable for the current slot |
| ctrl_ser | output | 1 | Serial status-flag stream |

## Verification
The bench targets the frame boundary. In one case input channel 31 of frame N must appear on output channel 0 of frame N+1. A design with a bank swap one position off would send the stale byte or the byte from the same frame. It also feeds a source byte that changes between consecutive frames. A design that loses the double buffer would then show the newer byte. Further cases cover a frame sync arriving mid-slot, a `drive_en` change mid-slot, and message slots mixed with disabled slots. Faults there show up as misaligned bits, enables that leak across slot boundaries, or switched data in place of the message byte. The control stream is compared every cycle against the status flags, which catches an index that is off by one position.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int STREAMS  = 8,
  parameter int CHANNELS = 32,
  localparam int SW  = $clog2(STREAMS),
  localparam int CW  = $clog2(CHANNELS),
  localparam int AW  = SW + CW,
  localparam int LW  = (AW > 8) ? AW : 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic [STREAMS-1:0] rx_ser,
  input  logic               drive_en,
  input  logic               map_we,
  input  logic [AW-1:0]      map_addr,
  input  logic [LW-1:0]      map_lo,
  input  logic [2:0]         map_hi,
  output logic [STREAMS-1:0] tx_ser,
  output logic [STREAMS-1:0] tx_oe,
  output logic               ctrl_ser
);
  localparam int LOC  = STREAMS * CHANNELS;
  localparam int PW   = CW + 3;
  localparam int LAST = CHANNELS * 8 - 1;
  localparam int F_MSG = 0, F_STAT = 1, F_DRV = 2;

  logic [PW-1:0] cnt, pos;
  logic          wbank;
  logic [7:0]    dmem   [2][LOC];
  logic [LW-1:0] cm_lo  [LOC];
  logic [2:0]    cm_hi  [LOC];
  logic [7:0]    rx_sh  [STREAMS];
  logic [7:0]    tx_sh  [STREAMS];
  logic          slot_en[STREAMS];
  logic          ctrl_q;

  assign pos = frame_sync ? '0 : cnt;
  wire [2:0]    bitpos = pos[2:0];
  wire [CW-1:0] chan   = pos[PW-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      wbank <= 1'b0;
    end else begin
      cnt <= (pos == PW'(LAST)) ? '0 : pos + 1'b1;
      if (pos == PW'(LAST)) wbank <= ~wbank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < LOC; i++) dmem[b][i] <= '0;
      for (int s = 0; s < STREAMS; s++) rx_sh[s] <= '0;
    end else begin
      for (int s = 0; s < STREAMS; s++) begin
        rx_sh[s] <= {rx_sh[s][6:0], rx_ser[s]};
        if (bitpos == 3'd7) dmem[wbank][{SW'(s), chan}] <= {rx_sh[s][6:0], rx_ser[s]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOC; i++) begin
        cm_lo[i] <= '0;
        cm_hi[i] <= '0;
      end
    end else if (map_we) begin
      cm_lo[map_addr] <= map_lo;
      cm_hi[map_addr] <= map_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b0;
    else        ctrl_q <= cm_hi[AW'(pos)][F_STAT];
  end
  assign ctrl_ser = ctrl_q;

  for (genvar o = 0; o < STREAMS; o++) begin : g_out
    wire [AW-1:0] sel     = {SW'(o), chan};
    wire [LW-1:0] lo      = cm_lo[sel];
    wire [2:0]    hi      = cm_hi[sel];
    wire [7:0]    sw_byte = dmem[!wbank][lo[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_sh[o]   <= '0;
        slot_en[o] <= 1'b0;
      end else if (bitpos == 3'd0) begin
        tx_sh[o]   <= hi[F_MSG] ? lo[7:0] : sw_byte;
        slot_en[o] <= hi[F_DRV];
      end else begin
        tx_sh[o] <= {tx_sh[o][6:0], 1'b0};
      end
    end

    assign tx_oe[o]  = drive_en & slot_en[o];
    assign tx_ser[o] = tx_oe[o] & tx_sh[o][7];
  end
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int STREAMS = 8,
  parameter int PW      = 8,
  parameter int LAST    = 255
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_sync,
  input logic               drive_en,
  input logic [STREAMS-1:0] tx_oe,
  input logic               ctrl_ser,
  input logic [PW-1:0]      cnt,
  input logic [PW-1:0]      pos,
  input logic               wbank
);
  p_reset_hiz_r1: assert property (@(posedge clk)
    !rst_n |-> (tx_oe == '0 && ctrl_ser == 1'b0));

  p_slot_oe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[2:0] != 3'd1 && $stable(drive_en)) |-> $stable(tx_oe));

  p_bank_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == PW'(LAST)) |=> (wbank != $past(wbank)));

  p_sync_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt == PW'(1)));

  p_pos_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && pos != PW'(LAST)) |=> (cnt == $past(pos) + 1'b1));
endmodule

bind tsi_switch tsi_switch_chk #(.STREAMS(STREAMS), .PW(PW), .LAST(LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .drive_en(drive_en),
  .tx_oe(tx_oe), .ctrl_ser(ctrl_ser), .cnt(cnt), .pos(pos), .wbank(wbank)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       frame_sync = 1'b0;
  logic [7:0] rx_ser = '0;
  logic       drive_en = 1'b1;
  logic       map_we = 1'b0;
  logic [7:0] map_addr = '0;
  logic [7:0] map_lo = '0;
  logic [2:0] map_hi = '0;
  logic [7:0] tx_ser, tx_oe;
  logic       ctrl_ser;

  tsi_switch u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_ser(rx_ser),
    .drive_en(drive_en), .map_we(map_we), .map_addr(map_addr), .map_lo(map_lo),
    .map_hi(map_hi), .tx_ser(tx_ser), .tx_oe(tx_oe), .ctrl_ser(ctrl_ser)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference
  int         mcnt, mp, wb;
  logic [7:0] rxm [2][256];
  logic [7:0] mlo [256];
  logic [2:0] mhi [256];
  logic [7:0] acc [8];
  logic [7:0] obyte [8];
  int         obit;
  logic       oen [8];
  logic       e_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; mp = 0; wb = 0; obit = 0; e_ctrl = 0;
      for (int i = 0; i < 256; i++) begin
        rxm[0][i] = 0; rxm[1][i] = 0; mlo[i] = 0; mhi[i] = 0;
      end
      for (int o = 0; o < 8; o++) begin
        acc[o] = 0; obyte[o] = 0; oen[o] = 0;
      end
    end else begin
      int p;
      p = frame_sync ? 0 : mcnt;
      mp = p;
      if (p % 8 == 0) begin
        for (int o = 0; o < 8; o++) begin
          int a;
          a = o * 32 + p / 8;
          oen[o]   = mhi[a][2];
          obyte[o] = mhi[a][0] ? mlo[a] : rxm[1 - wb][mlo[a]];
        end
        obit = 0;
      end else obit++;
      e_ctrl = mhi[p][1];
      for (int s = 0; s < 8; s++) begin
        acc[s] = {acc[s][6:0], rx_ser[s]};
        if (p % 8 == 7) rxm[wb][s * 32 + p / 8] = acc[s];
      end
      if (p == 255) wb = 1 - wb;
      mcnt = (p + 1) % 256;
      if (map_we) begin
        mlo[map_addr] = map_lo;
        mhi[map_addr] = map_hi;
      end
    end
  end

  // stimulus bytes for the current frame
  logic [7:0] txb [256];
  int         f_loc_a = -1, f_loc_b = -1;
  logic [7:0] f_val_a, f_val_b;
  bit         cap_on = 0;
  logic [7:0] cap2, cap3;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 30) $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] eoe, eser;
    for (int o = 0; o < 8; o++) begin
      eoe[o]  = drive_en && oen[o];
      eser[o] = eoe[o] && obyte[o][7 - obit];
    end
    check(tag, {15'd0, ctrl_ser, tx_oe, tx_ser}, {15'd0, e_ctrl, eoe, eser});
    if (cap_on && mp < 8)            cap3 = {cap3[6:0], tx_ser[3]};
    if (cap_on && mp >= 32 && mp < 40) cap2 = {cap2[6:0], tx_ser[2]};
  endtask

  task automatic tick(input bit fs);
    int np;
    frame_sync = fs;
    np = fs ? 0 : mcnt;
    if (np == 0) begin
      for (int i = 0; i < 256; i++) txb[i] = 8'($urandom);
      if (f_loc_a >= 0) txb[f_loc_a] = f_val_a;
      if (f_loc_b >= 0) txb[f_loc_b] = f_val_b;
    end
    for (int s = 0; s < 8; s++) rx_ser[s] = txb[s * 32 + np / 8][7 - np % 8];
    @(negedge clk);
    frame_sync = 0;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(0);
  endtask

  task automatic map_wr(input int a, input logic [7:0] lo, input logic [2:0] hi);
    map_we = 1; map_addr = 8'(a); map_lo = lo; map_hi = hi;
    tick(0);
    map_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) txb[i] = 0;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", {tx_oe, tx_ser, 7'd0, ctrl_ser}, 24'd0);
    rst_n = 1;

    tag = "R1"; run(300);

    // routing permutation with status flags
    tag = "R2 R5 R9";
    for (int a = 0; a < 256; a++)
      map_wr(a, 8'((a * 37 + 11) % 256), {1'b1, (a % 3 == 0), 1'b0});
    run(768);

    // broadcast: one source to many outputs
    tag = "R2";
    for (int a = 0; a < 256; a += 5) map_wr(a, 8'd77, 3'b100);
    run(600);

    // frame-edge and double-buffer directed checks
    tag = "R7";
    map_wr(2 * 32 + 4, 8'(5 * 32 + 9), 3'b100);
    map_wr(3 * 32 + 0, 8'(7 * 32 + 31), 3'b100);
    while (mcnt != 0) tick(0);
    f_loc_a = 5 * 32 + 9;  f_val_a = 8'hA5;
    f_loc_b = 7 * 32 + 31; f_val_b = 8'h5A;
    run(256);
    f_val_a = 8'h3C; f_val_b = 8'hC3;
    cap_on = 1;
    run(256);
    cap_on = 0;
    check("R7 R9", {24'd0, cap2}, {24'd0, 8'hA5});
    check("R7", {24'd0, cap3}, {24'd0, 8'h5A});
    f_loc_a = -1; f_loc_b = -1;

    // per-slot drive off on odd entries
    tag = "R3";
    for (int a = 1; a < 256; a += 2) map_wr(a, 8'(a), 3'b010);
    run(600);

    // message slots
    tag = "R4";
    for (int a = 0; a < 256; a += 4) map_wr(a, 8'(8'h80 | a[6:0]), 3'b101);
    run(600);

    // global drive gate, toggled mid-slot
    tag = "R6";
    run(3);
    drive_en = 0;
    run(300);
    check("R6", {24'd0, tx_oe | tx_ser}, 32'd0);
    drive_en = 1;
    run(300);

    // frame realignment mid-slot
    tag = "R8";
    run(101);
    tick(1);
    run(600);
    run(45);
    tick(1);
    run(520);

    // reset in mid run
    rst_n = 0;
    @(negedge clk);
    check("R1", {tx_oe, tx_ser, 7'd0, ctrl_ser}, 24'd0);
    rst_n = 1;
    tag = "R1";
    run(300);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule